// File: doc/BRIEF.md
# Timer-Based Serial Clock Generator

This block produces the bit clock for a synchronous serial port. A programmable timer counts ticks from one of two sources: an internal tick that fires once every `INT_DIV` core cycles (two by default, i.e. half the core rate), or the rising edges of an external clock after it has been brought into the core domain through a synchronizer. Each time the counter has seen a full period of ticks it reloads, and the output stage either emits a pulse one timer tick wide (pulse mode) or flips a square-wave output (clock mode, giving half the pulse rate at 50% duty).

The serial clock pin can play either role, chosen independently of the timer source: it either drives the generated clock out, or it accepts an external serial clock in, in which case the synchronized external level is what the port sees. A period value of zero parks the generator with its output low. A new period value is picked up only when the counter reloads, so a half-finished phase always completes at the old length.

Top module: `sclk_gen`

## Requirements
- R1: With `clk_mode_i`=0 (pulse mode), the internal source and period P≥2, `sclk_o` rises once every 2·P core cycles and stays high for exactly one timer tick (2 core cycles).
- R2: With `clk_mode_i`=1 (clock mode) and period P, `sclk_o` is a square wave that is high for P ticks and low for P ticks (2·P core cycles each with the internal source).
- R3: The internal source ticks once every `INT_DIV` core cycles (default 2), so clock mode with P=1 gives a 4-cycle square wave (2 high, 2 low).
- R4: With `src_ext_i`=1 the timer advances once per rising edge of `ext_clk_i` as seen after the synchronizer; with a 3-cycle external clock, pulse mode P=3 gives 3 high / 6 low and clock mode P=2 gives 6 high / 6 low.
- R5: With `pin_out_i`=1, `pin_oe_o`=1 and `sclk_o` carries the generated clock; with `pin_out_i`=0, `pin_oe_o`=0 and `sclk_o` follows `ext_clk_i` through `SYNC` (default 2) flops, whatever `src_ext_i` selects.
- R6: While the active period is zero, `sclk_o` (in drive-out role) stays low and the counter does not run; a later nonzero period starts the generator again.
- R7: A period write takes effect at the next counter reload; a write made during a phase (even in the last core cycle before the reload edge) shapes the following phase, and a value overwritten before any reload has no effect.
- R8: During and right after reset, with period zero, `sclk_o` is 0 and `pin_oe_o` reflects `pin_out_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | PW | Timer period in ticks (0 = stopped) |
| clk_mode_i | input | 1 | 0 = pulse output, 1 = square-wave output |
| src_ext_i | input | 1 | 0 = internal tick, 1 = external clock edges |
| pin_out_i | input | 1 | 1 = pin drives generated clock, 0 = pin is clock input |
| ext_clk_i | input | 1 | Asynchronous external clock |
| sclk_o | output | 1 | Selected serial clock |
| pin_oe_o | output | 1 | Drive enable for the serial clock pin |

## Verification
The two events that can land on the same clock edge are a period write by the user and the counter reload that latches the period. The bench provokes this by counting high samples of a clock-mode phase and changing `period_i` in the last core cycle before the terminal tick, then judges by the length of the following low phase, which must already use the new value; the same phase with an early write, and with a write that is reverted before the reload, frame this case from either side.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
   typedef enum logic {
      OUT_PULSE = 1'b0,
      OUT_CLOCK = 1'b1
   } out_mode_e;

   function automatic out_mode_e to_mode(input logic b);
      return b ? OUT_CLOCK : OUT_PULSE;
   endfunction
endpackage

// File: rtl/sclk_tick_src.sv
module sclk_tick_src #(
   parameter int INT_DIV = 2,
   parameter int SYNC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_ext_i,
   input  logic ext_clk_i,
   output logic tick_o,
   output logic ext_lvl_o,
   output logic ext_rise_o
);
   localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

   if (INT_DIV < 1) begin : g_bad_div
      $error("sclk_tick_src: INT_DIV must be at least 1");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("sclk_tick_src: SYNC must be at least 2");
   end

   logic int_tick;

   if (INT_DIV == 1) begin : g_div_none
      assign int_tick = 1'b1;
   end else begin : g_div_cnt
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            div_q <= '0;
         else if (div_q == DW'(INT_DIV - 1))
            div_q <= '0;
         else
            div_q <= div_q + DW'(1);
      end
      assign int_tick = (div_q == DW'(INT_DIV - 1));
   end

   logic [SYNC-1:0] sync_q;
   logic            prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC-2:0], ext_clk_i};
         prev_q <= sync_q[SYNC-1];
      end
   end

   assign ext_lvl_o  = sync_q[SYNC-1];
   assign ext_rise_o = sync_q[SYNC-1] & ~prev_q;
   assign tick_o     = src_ext_i ? ext_rise_o : int_tick;
endmodule

// File: rtl/sclk_timer.sv
module sclk_timer
   import sclk_pkg::*;
#(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [PW-1:0] period_i,
   input  logic          clk_mode_i,
   output logic [PW-1:0] prd_q,
   output logic [PW-1:0] cnt_q,
   output logic          pls_q,
   output logic          tog_q,
   output logic          gen_o
);
   if (PW < 2) begin : g_bad_pw
      $error("sclk_timer: PW must be at least 2");
   end

   out_mode_e mode;
   logic      terminal;

   assign mode     = to_mode(clk_mode_i);
   assign terminal = (cnt_q == prd_q - PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd_q <= '0;
         cnt_q <= '0;
         pls_q <= 1'b0;
         tog_q <= 1'b0;
      end else if (prd_q == '0) begin
         prd_q <= period_i;
         cnt_q <= '0;
         pls_q <= 1'b0;
         tog_q <= 1'b0;
      end else if (tick_i) begin
         pls_q <= 1'b0;
         if (terminal) begin
            cnt_q <= '0;
            prd_q <= period_i;
            if (mode == OUT_CLOCK)
               tog_q <= ~tog_q;
            else
               pls_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + PW'(1);
         end
      end
   end

   assign gen_o = (mode == OUT_CLOCK) ? tog_q : pls_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
   parameter int PW      = 16,
   parameter int INT_DIV = 2,
   parameter int SYNC    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period_i,
   input  logic          clk_mode_i,
   input  logic          src_ext_i,
   input  logic          pin_out_i,
   input  logic          ext_clk_i,
   output logic          sclk_o,
   output logic          pin_oe_o
);
   logic          tick;
   logic          ext_lvl;
   logic          ext_rise;
   logic [PW-1:0] prd_q;
   logic [PW-1:0] cnt_q;
   logic          pls_q;
   logic          tog_q;
   logic          gen;

   sclk_tick_src #(.INT_DIV(INT_DIV), .SYNC(SYNC)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_ext_i  (src_ext_i),
      .ext_clk_i  (ext_clk_i),
      .tick_o     (tick),
      .ext_lvl_o  (ext_lvl),
      .ext_rise_o (ext_rise)
   );

   sclk_timer #(.PW(PW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .period_i   (period_i),
      .clk_mode_i (clk_mode_i),
      .prd_q      (prd_q),
      .cnt_q      (cnt_q),
      .pls_q      (pls_q),
      .tog_q      (tog_q),
      .gen_o      (gen)
   );

   assign sclk_o   = pin_out_i ? gen : ext_lvl;
   assign pin_oe_o = pin_out_i;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          ext_rise,
   input logic [PW-1:0] prd_q,
   input logic [PW-1:0] cnt_q,
   input logic          pls_q,
   input logic          tog_q
);
   // R6: a zero active period clears both output state flops
   a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (prd_q == '0) |=> (!pls_q && !tog_q));

   // R1: a pulse ends at the next tick when the period exceeds one
   a_r1_pulse_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (pls_q && tick && prd_q > PW'(1)) |=> !pls_q);

   // R2: counter stays inside the active period
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (prd_q != '0) |-> (cnt_q < prd_q));

   // R7: output state only moves on a timer tick while running
   a_r7_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && prd_q != '0) |=> ($stable(pls_q) && $stable(tog_q)));

   // R4: a synchronized rising edge is never reported twice in a row
   a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);
endmodule

bind sclk_gen sclk_gen_chk #(.PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .ext_rise (ext_rise),
   .prd_q    (prd_q),
   .cnt_q    (cnt_q),
   .pls_q    (pls_q),
   .tog_q    (tog_q)
);

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] period_i = '0;
   logic          clk_mode_i = 1'b0;
   logic          src_ext_i = 1'b0;
   logic          pin_out_i = 1'b1;
   logic          ext_clk_i = 1'b0;
   logic          sclk_o;
   logic          pin_oe_o;

   int  n_cmp = 0;
   int  n_bad = 0;
   int  cyc = 0;
   bit  ext_run = 1'b0;
   int  ph = 0;

   always #5 clk = ~clk;

   sclk_gen #(.PW(PW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_i   (period_i),
      .clk_mode_i (clk_mode_i),
      .src_ext_i  (src_ext_i),
      .pin_out_i  (pin_out_i),
      .ext_clk_i  (ext_clk_i),
      .sclk_o     (sclk_o),
      .pin_oe_o   (pin_oe_o)
   );

   // external clock: 3 core cycles, high 2 / low 1
   always @(negedge clk) begin
      if (ext_run) begin
         ph = (ph == 2) ? 0 : ph + 1;
         ext_clk_i = (ph != 2);
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: act=%0d cycles exp=finish earlier", cyc);
         summary();
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic find_rise();
      bit prev;
      @(negedge clk);
      prev = sclk_o;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!prev && sclk_o) return;
         prev = sclk_o;
      end
   endtask

   task automatic measure(output int hi, output int lo);
      find_rise();
      hi = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!sclk_o) break;
         hi++;
      end
      lo = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (sclk_o) break;
         lo++;
      end
   endtask

   task automatic cfg(input int p, input bit mode, input bit src, input bit pin);
      int h, l;
      @(negedge clk);
      period_i   = PW'(p);
      clk_mode_i = mode;
      src_ext_i  = src;
      pin_out_i  = pin;
      measure(h, l);
      measure(h, l);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R8 sclk in reset", int'(sclk_o), 0);
      chk("R8 oe in reset", int'(pin_oe_o), 1);
      rst_n = 1'b1;
      begin
         int highs = 0;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            highs += int'(sclk_o);
         end
         chk("R8 low after reset", highs, 0);
      end
   endtask

   task automatic t_pulse_int();
      int h, l;
      cfg(3, 1'b0, 1'b0, 1'b1);
      measure(h, l);
      chk("R1 P=3 high", h, 2);
      chk("R1 P=3 low", l, 4);
      cfg(5, 1'b0, 1'b0, 1'b1);
      measure(h, l);
      chk("R1 P=5 high", h, 2);
      chk("R1 P=5 low", l, 8);
   endtask

   task automatic t_clock_int();
      int h, l;
      cfg(3, 1'b1, 1'b0, 1'b1);
      measure(h, l);
      chk("R2 P=3 high", h, 6);
      chk("R2 P=3 low", l, 6);
      cfg(1, 1'b1, 1'b0, 1'b1);
      measure(h, l);
      chk("R3 P=1 high", h, 2);
      chk("R3 P=1 low", l, 2);
   endtask

   task automatic t_ext_src();
      int h, l;
      ext_run = 1'b1;
      cfg(3, 1'b0, 1'b1, 1'b1);
      measure(h, l);
      chk("R4 ext pulse high", h, 3);
      chk("R4 ext pulse low", l, 6);
      cfg(2, 1'b1, 1'b1, 1'b1);
      measure(h, l);
      chk("R4 ext clock high", h, 6);
      chk("R4 ext clock low", l, 6);
   endtask

   task automatic t_pin_dir();
      int h, l;
      cfg(4, 1'b1, 1'b0, 1'b0);
      chk("R5 oe off", int'(pin_oe_o), 0);
      measure(h, l);
      chk("R5 pin-in high", h, 2);
      chk("R5 pin-in low", l, 1);
      cfg(4, 1'b1, 1'b1, 1'b0);
      measure(h, l);
      chk("R5 pin-in ext src high", h, 2);
      chk("R5 pin-in ext src low", l, 1);
      cfg(2, 1'b1, 1'b0, 1'b1);
      chk("R5 oe on", int'(pin_oe_o), 1);
      measure(h, l);
      chk("R5 drive-out high", h, 4);
      ext_run = 1'b0;
   endtask

   task automatic t_zero();
      int h, l, highs;
      cfg(2, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      period_i = '0;
      repeat (16) @(negedge clk);
      highs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         highs += int'(sclk_o);
      end
      chk("R6 zero holds low", highs, 0);
      period_i = PW'(2);
      measure(h, l);
      chk("R6 restart high", h, 4);
      chk("R6 restart low", l, 4);
   endtask

   // write during a high phase of clock mode P=3 at sample index wr_at,
   // optionally reverting at sample index rv_at (0 = no revert)
   task automatic upd_case(input string req, input int wr_at, input int rv_at,
                           input int exp_lo);
      int h, l;
      cfg(3, 1'b1, 1'b0, 1'b1);
      find_rise();
      h = 1;
      if (wr_at == 1) period_i = PW'(2);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!sclk_o) break;
         h++;
         if (h == wr_at) period_i = PW'(2);
         if (h == rv_at) period_i = PW'(3);
      end
      l = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sclk_o) break;
         l++;
      end
      chk({req, " high"}, h, 6);
      chk({req, " low"}, l, exp_lo);
   endtask

   task automatic t_update();
      upd_case("R7 early write", 1, 0, 4);
      upd_case("R7 write on reload edge", 6, 0, 4);
      upd_case("R7 overwritten write ignored", 2, 3, 6);
   endtask

   initial begin
      t_reset();
      t_pulse_int();
      t_clock_int();
      t_ext_src();
      t_pin_dir();
      t_zero();
      t_update();
      summary();
   end
endmodule